// File: doc/BRIEF.md
# Buffered Block-Copy DMA Engine

This engine is a bus master on a pipelined Wishbone bus that copies a block of words from a slow source memory, such as a serial flash controller, into a fast destination memory, such as block RAM. Each start takes a source word address, a destination word address and a word count. Software then sees `busy` while the copy runs, followed by a one-cycle `done` and an error flag.

The copy runs as alternating phases. A read phase sends source reads back to back without waiting for acknowledges and puts the returned words into an internal buffer of 1024 words. A write phase then empties that buffer to the destination as a continuous burst, one request per clock when the slave does not stall. `wb_cyc` stays high for the whole of a phase and drops for at least one clock between phases. A copy longer than the buffer is handled as repeated read-then-write chunks, and the last chunk carries only the words that remain. A bus error response ends the copy at once and raises the error flag.

Top module: `dma_block_copy`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `wb_cyc` and `wb_stb` are all low.
- R2: A read phase issues only reads (`wb_we`=0) to consecutive source addresses starting at `src_addr`, without waiting for acknowledges, so more than one read can be outstanding. No write is issued within a read phase. In the cycle after `start` is sampled with a nonzero length, `busy`, `wb_cyc` and `wb_stb` are high and `wb_adr` equals `src_addr`.
- R3: Each read phase moves min(remaining, 1024) words. The write phase that follows writes those same words, in the same order, to consecutive destination addresses that carry on from the previous chunk.
- R4: With `wb_stall` low, the strobe of a write phase stays high on every clock until all of that phase's writes are issued, with no gap.
- R5: A phase ends only after every issued request is acknowledged. `wb_cyc` is high throughout a phase, `wb_stb` is never high without `wb_cyc`, and `wb_cyc` is low for at least one cycle between two phases.
- R6: While `wb_stb` is high and `wb_stall` is high, the next cycle keeps `wb_stb` high with `wb_adr`, `wb_we` and `wb_dat_w` unchanged.
- R7: A length longer than 1024 words is copied correctly across several chunks, and destination words outside the requested range are not written.
- R8: `done` is a one-cycle pulse with `busy` and `wb_cyc` low, raised in the cycle after the last acknowledge. A start with length 0 gives `done` in the next cycle and issues no bus cycle.
- R9: When `wb_err` is sampled during a cycle, `wb_cyc` is low in the next cycle and `done` rises together with `err`=1. `err` changes only at a bus error or when the next `start` clears it.
- R10: Every request drives `wb_sel` all ones (whole-word transfers).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a copy, sampled only while idle |
| src_addr | input | AW | First source word address |
| dst_addr | input | AW | First destination word address |
| xfer_len | input | LW | Number of words to copy |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle end-of-copy pulse |
| err | output | 1 | Last copy ended on a bus error |
| wb_cyc | output | 1 | Bus cycle, high for a whole phase |
| wb_stb | output | 1 | Request strobe |
| wb_we | output | 1 | Write enable (1 in write phases) |
| wb_adr | output | AW | Word address |
| wb_dat_w | output | DW | Write data |
| wb_sel | output | DW/8 | Byte selects, all ones |
| wb_stall | input | 1 | Slave cannot accept the request this cycle |
| wb_ack | input | 1 | Request completed |
| wb_err | input | 1 | Request failed |
| wb_dat_r | input | DW | Read data |

## Verification
The bench drives a pipelined slave model with fixed latencies from one to five cycles and an optional pseudo-random stall. It copies lengths of 1, 5, exactly one buffer, one buffer plus six, and just over two buffers, then checks the phase sizes, the addresses and the data of every chunk. A design that cut off the short final chunk, or overran it, shows up as the wrong word count in the last phase or as a sentinel word just past the destination that was overwritten. One that waited for each acknowledge never reaches two outstanding reads, and one whose buffer read lagged would leave gaps in the write strobe or would move the address or data during a stall. The error case injects a failed response partway through a read phase, and the bench expects the cycle to drop at once, no write to reach the destination, and the flag to clear on the next start.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_TURN  = 3'd2,
    ST_WRITE = 3'd3,
    ST_NEXT  = 3'd4,
    ST_FIN   = 3'd5
  } dma_state_e;

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/dma_phase_track.sv
// Per-phase counters of issued and answered requests.
module dma_phase_track #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          issue,
  input  logic          resp,
  input  logic [CW-1:0] limit,
  output logic          more,
  output logic          last_resp,
  output logic [CW-1:0] iss_cnt,
  output logic [CW-1:0] rsp_cnt
);

  logic [CW-1:0] iss_q, iss_d;
  logic [CW-1:0] rsp_q, rsp_d;

  always_comb begin
    iss_d = iss_q;
    rsp_d = rsp_q;
    if (clr) begin
      iss_d = '0;
      rsp_d = '0;
    end else begin
      if (issue) iss_d = iss_q + 1'b1;
      if (resp)  rsp_d = rsp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_q <= '0;
      rsp_q <= '0;
    end else begin
      iss_q <= iss_d;
      rsp_q <= rsp_d;
    end
  end

  assign more      = (iss_q != limit);
  assign last_resp = resp && (CW'(rsp_q + 1'b1) == limit);
  assign iss_cnt   = iss_q;
  assign rsp_cnt   = rsp_q;

endmodule

// File: rtl/dma_buf.sv
// Chunk buffer: one write port, one registered read port.
module dma_buf #(
  parameter int DW = 32,
  parameter int LG = 10
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [LG-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [LG-1:0] rd_idx,
  output logic [DW-1:0] rd_q
);

  localparam int DEPTH = 1 << LG;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_idx];
  end

endmodule

// File: rtl/dma_block_copy.sv
module dma_block_copy
  import dma_pkg::*;
#(
  parameter int AW    = 24,
  parameter int DW    = 32,
  parameter int LGBUF = 10,
  parameter int LW    = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   src_addr,
  input  logic [AW-1:0]   dst_addr,
  input  logic [LW-1:0]   xfer_len,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic            wb_cyc,
  output logic            wb_stb,
  output logic            wb_we,
  output logic [AW-1:0]   wb_adr,
  output logic [DW-1:0]   wb_dat_w,
  output logic [DW/8-1:0] wb_sel,
  input  logic            wb_stall,
  input  logic            wb_ack,
  input  logic            wb_err,
  input  logic [DW-1:0]   wb_dat_r
);

  localparam int BUF_WORDS = 1 << LGBUF;
  localparam int CW        = LGBUF + 1;
  localparam int SW        = DW / 8;

  function automatic logic [CW-1:0] clip_chunk(input logic [LW-1:0] r);
    return (r >= LW'(BUF_WORDS)) ? CW'(BUF_WORDS) : CW'(r);
  endfunction

  logic rst_n_s;

  dma_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_s)
  );

  dma_state_e    state_q, state_d;
  logic [AW-1:0] src_q, src_d;
  logic [AW-1:0] dst_q, dst_d;
  logic [LW-1:0] rem_q, rem_d;
  logic [CW-1:0] chunk_q, chunk_d;
  logic          err_q, err_d;

  logic          in_rd, in_wr;
  logic          accept, resp;
  logic          more, last_resp;
  logic [CW-1:0] iss_cnt, rsp_cnt;
  logic          buf_wr_en, buf_rd_en;
  logic [LGBUF-1:0] buf_rd_idx;
  logic [LW-1:0] rem_after;

  assign in_rd  = (state_q == ST_READ);
  assign in_wr  = (state_q == ST_WRITE);
  assign wb_cyc = in_rd || in_wr;
  assign wb_stb = wb_cyc && more;
  assign wb_we  = in_wr;
  assign wb_adr = in_wr ? dst_q : src_q;
  assign wb_sel = {SW{1'b1}};
  assign accept = wb_stb && !wb_stall;
  assign resp   = wb_cyc && wb_ack;

  dma_phase_track #(.CW(CW)) u_track (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clr       (!wb_cyc),
    .issue     (accept),
    .resp      (resp),
    .limit     (chunk_q),
    .more      (more),
    .last_resp (last_resp),
    .iss_cnt   (iss_cnt),
    .rsp_cnt   (rsp_cnt)
  );

  assign buf_wr_en  = in_rd && wb_ack && !wb_err;
  assign buf_rd_en  = (state_q == ST_TURN) || (in_wr && accept);
  assign buf_rd_idx = (state_q == ST_TURN) ? '0 : LGBUF'(iss_cnt + 1'b1);

  dma_buf #(.DW(DW), .LG(LGBUF)) u_buf (
    .clk     (clk),
    .wr_en   (buf_wr_en),
    .wr_idx  (LGBUF'(rsp_cnt)),
    .wr_data (wb_dat_r),
    .rd_en   (buf_rd_en),
    .rd_idx  (buf_rd_idx),
    .rd_q    (wb_dat_w)
  );

  assign rem_after = rem_q - LW'(chunk_q);

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    dst_d   = dst_q;
    rem_d   = rem_q;
    chunk_d = chunk_q;
    err_d   = err_q;
    if (in_rd && accept) src_d = src_q + 1'b1;
    if (in_wr && accept) dst_d = dst_q + 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          src_d   = src_addr;
          dst_d   = dst_addr;
          rem_d   = xfer_len;
          chunk_d = clip_chunk(xfer_len);
          err_d   = 1'b0;
          state_d = (xfer_len == '0) ? ST_FIN : ST_READ;
        end
      end
      ST_READ: begin
        if (wb_err) begin
          err_d   = 1'b1;
          state_d = ST_FIN;
        end else if (last_resp) begin
          state_d = ST_TURN;
        end
      end
      ST_TURN: state_d = ST_WRITE;
      ST_WRITE: begin
        if (wb_err) begin
          err_d   = 1'b1;
          state_d = ST_FIN;
        end else if (last_resp) begin
          rem_d   = rem_after;
          chunk_d = clip_chunk(rem_after);
          state_d = (rem_after == '0) ? ST_FIN : ST_NEXT;
        end
      end
      ST_NEXT: state_d = ST_READ;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
      chunk_q <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      rem_q   <= rem_d;
      chunk_q <= chunk_d;
      err_q   <= err_d;
    end
  end

  assign busy = (state_q == ST_READ) || (state_q == ST_TURN) ||
                (state_q == ST_WRITE) || (state_q == ST_NEXT);
  assign done = (state_q == ST_FIN);
  assign err  = err_q;

endmodule

// File: rtl/dma_block_copy_chk.sv
module dma_block_copy_chk #(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic            wb_cyc,
  input logic            wb_stb,
  input logic            wb_we,
  input logic [AW-1:0]   wb_adr,
  input logic [DW-1:0]   wb_dat_w,
  input logic [DW/8-1:0] wb_sel,
  input logic            wb_stall,
  input logic            wb_ack,
  input logic            wb_err
);

  logic [15:0] pend_q;
  logic [15:0] pend_n;

  assign pend_n = pend_q + 16'(wb_stb && !wb_stall) - 16'(wb_ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else if (!wb_cyc) pend_q <= '0;
    else pend_q <= pend_n;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_stb && wb_stall && !wb_err) |=> (wb_stb && $stable(wb_adr) && $stable(wb_we) && $stable(wb_dat_w))); // R6

  AST_CYC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && !wb_err && pend_n != 16'd0) |=> wb_cyc); // R5

  AST_STB_IN_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb |-> wb_cyc); // R5

  AST_WE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && $past(wb_cyc)) |-> $stable(wb_we)); // R2

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!wb_cyc && !busy)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_ERR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && wb_err) |=> (!wb_cyc && done && err)); // R9

  AST_ERR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !wb_err) |=> $stable(err)); // R9

  AST_FULL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb |-> (&wb_sel)); // R10

endmodule

bind dma_block_copy dma_block_copy_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .wb_cyc   (wb_cyc),
  .wb_stb   (wb_stb),
  .wb_we    (wb_we),
  .wb_adr   (wb_adr),
  .wb_dat_w (wb_dat_w),
  .wb_sel   (wb_sel),
  .wb_stall (wb_stall),
  .wb_ack   (wb_ack),
  .wb_err   (wb_err)
);

// File: tb/dma_block_copy_tb.sv
`timescale 1ns/1ps
module dma_block_copy_tb;

  localparam int AW = 24;
  localparam int DW = 32;
  localparam int LW = 20;
  localparam int BUFW = 1024;
  localparam logic [31:0] SENT = 32'hDEADBEEF;

  localparam int NV = 5;
  localparam int V_LEN   [0:NV-1] = '{5, 1024, 1030, 2100, 1};
  localparam int V_LAT   [0:NV-1] = '{1, 3, 2, 5, 4};
  localparam int V_STALL [0:NV-1] = '{0, 0, 1, 1, 1};
  localparam int V_SRC   [0:NV-1] = '{100, 0, 777, 10, 3000};
  localparam int V_DST   [0:NV-1] = '{5000, 4099, 5000, 4200, 8000};

  logic clk;
  logic rst_n;
  logic start;
  logic [AW-1:0] src_addr, dst_addr;
  logic [LW-1:0] xfer_len;
  logic busy, done, err;
  logic wb_cyc, wb_stb, wb_we;
  logic [AW-1:0] wb_adr;
  logic [DW-1:0] wb_dat_w;
  logic [DW/8-1:0] wb_sel;
  logic wb_stall, wb_ack, wb_err;
  logic [DW-1:0] wb_dat_r;

  dma_block_copy #(.AW(AW), .DW(DW), .LGBUF(10), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
    .dst_addr(dst_addr), .xfer_len(xfer_len), .busy(busy), .done(done),
    .err(err), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_sel(wb_sel),
    .wb_stall(wb_stall), .wb_ack(wb_ack), .wb_err(wb_err), .wb_dat_r(wb_dat_r)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // slave model state
  logic [31:0] mem [0:8191];
  bit          pv [0:7];
  bit          pe [0:7];
  logic [31:0] pd [0:7];
  int  lat = 1;
  bit  stall_on = 0;
  int  err_at = -1;
  int  resp_idx = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit  acc_flag = 0, acc_we = 0;
  logic [AW-1:0] acc_adr;
  logic [31:0] acc_dat;
  bit  hold_pend = 0, hold_we = 0;
  logic [AW-1:0] hold_adr;
  logic [31:0] hold_dat;
  bit  err_was_out = 0;
  bit  cyc_prev = 0;

  // monitor state
  int  base_src = 0, base_dst = 0, rd_seen = 0, wr_seen = 0;
  int  stall_viol = 0, errdrop_viol = 0, mix_viol = 0, bubble = 0;
  int  addr_viol = 0, unacked = 0, sel_viol = 0, max_out = 0;
  int  nph = 0;
  int  phase_cnt [0:15];
  bit  phase_we [0:15];
  bit  ph_we = 0, stb_fell = 0;
  int  ph_acc = 0, ph_ack = 0;

  initial begin
    wb_stall = 1'b0;
    wb_ack   = 1'b0;
    wb_err   = 1'b0;
    wb_dat_r = '0;
    for (int i = 0; i < 8; i++) begin pv[i] = 0; pe[i] = 0; pd[i] = '0; end
    forever begin
      @(negedge clk);
      // monitor
      if (hold_pend && (!wb_stb || wb_adr != hold_adr || wb_dat_w != hold_dat || wb_we != hold_we))
        stall_viol++;
      if (err_was_out && wb_cyc) errdrop_viol++;
      if (wb_stb && wb_sel != 4'hF) sel_viol++;
      if (wb_cyc && !cyc_prev) begin
        ph_we = wb_we; ph_acc = 0; ph_ack = 0; stb_fell = 0;
      end
      if (wb_cyc) begin
        if (wb_stb && wb_we != ph_we) mix_viol++;
        if (wb_stb && stb_fell && wb_we && !stall_on) bubble++;
        if (!wb_stb && ph_acc > 0) stb_fell = 1;
      end
      if (!wb_cyc && cyc_prev) begin
        if (nph < 16) begin phase_cnt[nph] = ph_acc; phase_we[nph] = ph_we; end
        nph++;
        if (ph_ack != ph_acc && !err_was_out) unacked++;
      end
      // slave responses
      for (int i = 0; i < 7; i++) begin pv[i] = pv[i+1]; pe[i] = pe[i+1]; pd[i] = pd[i+1]; end
      pv[7] = 0; pe[7] = 0;
      if (!wb_cyc) for (int i = 0; i < 8; i++) pv[i] = 0;
      if (acc_flag && wb_cyc) begin
        pv[lat-1] = 1;
        pe[lat-1] = (resp_idx == err_at);
        if (acc_we) begin
          if (resp_idx != err_at) mem[acc_adr[12:0]] = acc_dat;
        end else begin
          pd[lat-1] = mem[acc_adr[12:0]];
        end
        resp_idx++;
      end
      wb_ack   = pv[0] && !pe[0];
      wb_err   = pv[0] && pe[0];
      wb_dat_r = pd[0];
      if (wb_ack) ph_ack++;
      err_was_out = wb_err;
      // stall decision for next edge
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wb_stall = stall_on && lfsr[0] && lfsr[3];
      acc_flag = wb_cyc && wb_stb && !wb_stall && !wb_err;
      if (acc_flag) begin
        acc_we = wb_we; acc_adr = wb_adr; acc_dat = wb_dat_w;
        ph_acc++;
        if (wb_we) begin
          if (wb_adr != AW'(base_dst + wr_seen)) addr_viol++;
          wr_seen++;
        end else begin
          if (wb_adr != AW'(base_src + rd_seen)) addr_viol++;
          rd_seen++;
        end
        if (ph_acc - ph_ack > max_out) max_out = ph_acc - ph_ack;
      end
      hold_pend = wb_cyc && wb_stb && wb_stall && !wb_err;
      hold_we = wb_we; hold_adr = wb_adr; hold_dat = wb_dat_w;
      cyc_prev = wb_cyc;
    end
  end

  function automatic logic [31:0] pat(input int a, input int c);
    return (32'(a) * 32'h9E3779B1) ^ {8'(c), 24'h5A5A5A};
  endfunction

  task automatic prep(input int c, input int s, input int d, input int l,
                      input int lt, input int st, input int ea);
    for (int i = 0; i < 4096; i++) mem[i] = pat(i, c);
    for (int i = 4096; i < 8192; i++) mem[i] = SENT;
    base_src = s; base_dst = d; rd_seen = 0; wr_seen = 0;
    stall_viol = 0; errdrop_viol = 0; mix_viol = 0; bubble = 0;
    addr_viol = 0; unacked = 0; sel_viol = 0; max_out = 0; nph = 0;
    lat = lt; stall_on = (st != 0); err_at = ea; resp_idx = 0;
    src_addr = AW'(s); dst_addr = AW'(d); xfer_len = LW'(l);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(posedge clk); #5;
    start = 1'b0;
  endtask

  task automatic wait_done(output bit seen, output bit e);
    seen = 0; e = 0;
    for (int i = 0; i < 60000; i++) begin
      if (done) begin seen = 1; e = err; break; end
      @(posedge clk); #5;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit seen, e;
    int rem, nch, bad;
    start = 0; src_addr = '0; dst_addr = '0; xfer_len = '0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #5 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #5;
    // R1 reset state
    chk(!busy && !done && !err, "R1", "busy/done/err after reset", {busy, done, err}, 0);
    chk(!wb_cyc && !wb_stb, "R1", "cyc/stb after reset", {wb_cyc, wb_stb}, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      prep(v, V_SRC[v], V_DST[v], V_LEN[v], V_LAT[v], V_STALL[v], -1);
      pulse_start();
      chk(busy && wb_cyc && wb_stb && !wb_we && wb_adr == AW'(V_SRC[v]), "R2",
          "first read after start", wb_adr, V_SRC[v]);
      wait_done(seen, e);
      chk(seen && !e, "R8", "done without error", {seen, e}, 2);
      @(posedge clk); #5;
      chk(!done && !busy, "R8", "done is one pulse", {done, busy}, 0);
      bad = 0;
      for (int i = 0; i < V_LEN[v]; i++)
        if (mem[V_DST[v] + i] != pat(V_SRC[v] + i, v)) bad++;
      chk(bad == 0, V_LEN[v] > BUFW ? "R7" : "R3", "destination words wrong", bad, 0);
      chk(mem[V_DST[v] - 1] == SENT && (V_DST[v] + V_LEN[v] > 8191 || mem[V_DST[v] + V_LEN[v]] == SENT),
          "R7", "word outside range written", 1, 0);
      nch = (V_LEN[v] + BUFW - 1) / BUFW;
      chk(nph == 2 * nch, "R5", "phase count", nph, 2 * nch);
      bad = 0; rem = V_LEN[v];
      for (int k = 0; k < nch && 2 * k + 1 < 16; k++) begin
        int exp_c;
        exp_c = rem > BUFW ? BUFW : rem;
        if (phase_cnt[2*k] != exp_c || phase_we[2*k] != 0) bad++;
        if (phase_cnt[2*k+1] != exp_c || phase_we[2*k+1] != 1) bad++;
        rem -= exp_c;
      end
      chk(bad == 0, "R3", "chunk sizes per phase", bad, 0);
      chk(addr_viol == 0, "R3", "address sequence", addr_viol, 0);
      chk(mix_viol == 0, "R2", "mixed read/write in phase", mix_viol, 0);
      chk(unacked == 0, "R5", "phase ended with requests open", unacked, 0);
      chk(sel_viol == 0, "R10", "byte selects", sel_viol, 0);
      if (V_STALL[v] == 0)
        chk(bubble == 0, "R4", "write strobe gaps", bubble, 0);
      else
        chk(stall_viol == 0, "R6", "request changed under stall", stall_viol, 0);
      if (V_LAT[v] > 1 && V_LEN[v] > 1)
        chk(max_out > 1, "R2", "outstanding reads", max_out, 2);
      repeat (3) @(posedge clk); #5;
    end

    // zero length
    prep(7, 20, 6000, 0, 1, 0, -1);
    pulse_start();
    chk(done && !wb_cyc && !busy, "R8", "zero length done next cycle", {done, wb_cyc, busy}, 4);
    @(posedge clk); #5;
    chk(nph == 0 && !done, "R8", "zero length bus cycles", nph, 0);

    // bus error in read phase
    prep(8, 50, 6000, 40, 2, 0, 10);
    pulse_start();
    wait_done(seen, e);
    chk(seen && e, "R9", "done with error flag", {seen, e}, 3);
    @(posedge clk); #5;
    chk(errdrop_viol == 0, "R9", "cycle held after error", errdrop_viol, 0);
    chk(mem[6000] == SENT && err, "R9", "write after error / flag held", mem[6000] == SENT, 1);
    prep(9, 20, 6000, 0, 1, 0, -1);
    pulse_start();
    chk(done && !err, "R9", "flag cleared by next start", err, 0);

    @(posedge clk); #5;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule